// File: doc/BRIEF.md
# Reversing Motor Starter Interlock

This block drives the two direction contactor outputs of a reversible motor. Two momentary buttons request forward or reverse running, a shared stop input and an overload input remove power, and each direction holds itself on after its button is released. The two outputs are mutually exclusive. Reversal has to pass through a stop, and after a direction drops out the opposite direction stays locked out for a changeover dead time. That dead time gives the first contactor time to open mechanically before the second one closes.

All inputs are synchronous, already-debounced level bits. The stop and overload inputs are fail-safe: they read 1 when healthy, so a broken wire reads as a stop. The dead time is counted in pulses of a one-cycle 1 ms tick enable, and its length is the parameter `DELAY_MS`, intended for 200 to 500. The interlock is taken from the block's own direction flags and never from the button inputs.

Top module: `rev_starter`

## Requirements
- R1: After reset both outputs are low and no changeover lockout is pending, so either direction may start at the first press.
- R2: With stop_ok and ol_ok both 1 and the block stopped, fwd_btn=1 with rev_btn=0 raises fwd_out after the next rising clock edge. fwd_out then stays high after the button is released, for as long as stop_ok and ol_ok stay 1.
- R3: Under the same conditions, rev_btn=1 with fwd_btn=0 raises rev_out after the next rising edge, and rev_out holds after release in the same way.
- R4: fwd_out and rev_out are never both 1 in the same cycle.
- R5: stop_ok=0 forces both outputs to 0 in that same cycle and clears the running direction at the next edge. Once stop_ok returns to 1, the outputs stay 0 until a new start press.
- R6: ol_ok=0 forces both outputs to 0 in that same cycle and clears the running direction. While ol_ok is 0, no start press has any effect.
- R7: While one direction is running, pressing the opposite start button, alone or together with the running direction's button, has no effect.
- R8: The edge that drops a direction begins a lockout. During the lockout the opposite direction cannot start until DELAY_MS tick_1ms pulses have been counted after that edge. A press after exactly DELAY_MS pulses starts it, and a press after DELAY_MS-1 pulses does not. Restarting the direction that dropped is not locked out.
- R9: From the stopped state, fwd_btn and rev_btn both at 1 in the same cycle start neither direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_1ms | input | 1 | One-cycle pulse every millisecond; counts the changeover dead time |
| fwd_btn | input | 1 | Forward start request, momentary, active-high |
| rev_btn | input | 1 | Reverse start request, momentary, active-high |
| stop_ok | input | 1 | Stop circuit healthy (1 at rest, 0 when pressed or broken) |
| ol_ok | input | 1 | Overload relay healthy (1 healthy, 0 tripped) |
| fwd_out | output | 1 | Forward contactor drive |
| rev_out | output | 1 | Reverse contactor drive |

## Verification
The hardest situation to reach from the ports is the exact boundary of the changeover lockout. An opposite-direction press must be refused after DELAY_MS-1 tick pulses and accepted after DELAY_MS. The bench gets there by running one direction, dropping it with a single low cycle on stop_ok, and then feeding a counted number of tick_1ms pulses with the buttons idle before it tries the opposite start. Around that, a sweep walks each of the three running states through all sixteen combinations of buttons, stop and overload. Before each trial it clears any lockout, so that every combination is judged on its own.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  // Records which direction caused the pending changeover lockout
  typedef enum logic [1:0] {
    LAST_NONE = 2'd0,
    LAST_FWD  = 2'd1,
    LAST_REV  = 2'd2
  } last_dir_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((max_val >> w) != 0) w++;
    return w;
  endfunction
endpackage

// File: rtl/rsm_rst_sync.sv
module rsm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/rsm_changeover_timer.sv
module rsm_changeover_timer
  import rsm_pkg::*;
#(
  parameter int unsigned DELAY_MS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic drop_fwd,
  input  logic drop_rev,
  output logic blk_fwd,
  output logic blk_rev
);
  localparam int unsigned CW = cnt_width(DELAY_MS);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_MS);

  logic [CW-1:0] cnt_q, cnt_d;
  last_dir_e     last_q, last_d;
  logic          busy;

  assign busy = (cnt_q != '0);

  // Next-state: a new drop reloads the window, otherwise count ticks down
  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (drop_fwd) begin
      cnt_d  = LOAD_VAL;
      last_d = LAST_FWD;
    end else if (drop_rev) begin
      cnt_d  = LOAD_VAL;
      last_d = LAST_REV;
    end else if (tick && busy) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) last_d = LAST_NONE;
    end
  end

  // Reset leaves the window already expired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= LAST_NONE;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  // Only the opposite of the direction that dropped is held off
  assign blk_fwd = busy && (last_q == LAST_REV);
  assign blk_rev = busy && (last_q == LAST_FWD);
endmodule

// File: rtl/rsm_dir_ctrl.sv
module rsm_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_btn,
  input  logic rev_btn,
  input  logic healthy,
  input  logic blk_fwd,
  input  logic blk_rev,
  output logic fwd_q,
  output logic rev_q,
  output logic drop_fwd,
  output logic drop_rev
);
  logic fwd_d, rev_d;
  logic idle, fwd_start, rev_start;

  assign idle = !fwd_q && !rev_q;

  // Start terms: stopped, single button, no lockout for that direction
  assign fwd_start = idle && fwd_btn && !rev_btn && !blk_fwd;
  assign rev_start = idle && rev_btn && !fwd_btn && !blk_rev;

  // Seal-in through the own flag, interlocked on the other flag
  always_comb begin
    fwd_d = healthy && !rev_q && (fwd_q || fwd_start);
    rev_d = healthy && !fwd_q && (rev_q || rev_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b0;
      rev_q <= 1'b0;
    end else begin
      fwd_q <= fwd_d;
      rev_q <= rev_d;
    end
  end

  assign drop_fwd = fwd_q && !fwd_d;
  assign drop_rev = rev_q && !rev_d;
endmodule

// File: rtl/rev_starter.sv
module rev_starter #(
  parameter int unsigned DELAY_MS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic fwd_btn,
  input  logic rev_btn,
  input  logic stop_ok,
  input  logic ol_ok,
  output logic fwd_out,
  output logic rev_out
);
  logic rst_sync_n;
  logic healthy;
  logic fwd_q, rev_q;
  logic drop_fwd, drop_rev;
  logic blk_fwd, blk_rev;

  assign healthy = stop_ok && ol_ok;

  rsm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rsm_dir_ctrl u_dir (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fwd_btn  (fwd_btn),
    .rev_btn  (rev_btn),
    .healthy  (healthy),
    .blk_fwd  (blk_fwd),
    .blk_rev  (blk_rev),
    .fwd_q    (fwd_q),
    .rev_q    (rev_q),
    .drop_fwd (drop_fwd),
    .drop_rev (drop_rev)
  );

  rsm_changeover_timer #(.DELAY_MS(DELAY_MS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_1ms),
    .drop_fwd (drop_fwd),
    .drop_rev (drop_rev),
    .blk_fwd  (blk_fwd),
    .blk_rev  (blk_rev)
  );

  // Outputs are gated directly by the safety inputs so they drop this cycle
  assign fwd_out = fwd_q && healthy;
  assign rev_out = rev_q && healthy;
endmodule

// File: rtl/rev_starter_chk.sv
module rev_starter_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic fwd_btn,
  input logic rev_btn,
  input logic stop_ok,
  input logic ol_ok,
  input logic fwd_out,
  input logic rev_out
);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(fwd_out && rev_out));

  a_r5_stop_kills: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stop_ok |-> (!fwd_out && !rev_out));

  a_r6_overload_kills: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ol_ok |-> (!fwd_out && !rev_out));

  a_r2_fwd_seal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fwd_out && stop_ok && ol_ok) |=> (fwd_out || !stop_ok || !ol_ok));

  a_r3_rev_seal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rev_out && stop_ok && ol_ok) |=> (rev_out || !stop_ok || !ol_ok));

  a_r7_no_direct_reverse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fwd_out |=> !rev_out);

  a_r8_dead_time_after_fwd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(fwd_out) |=> !rev_out);

  a_r9_both_buttons: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!fwd_out && !rev_out && stop_ok && ol_ok && fwd_btn && rev_btn)
      |=> (!fwd_out && !rev_out));
endmodule

bind rev_starter rev_starter_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .fwd_btn    (fwd_btn),
  .rev_btn    (rev_btn),
  .stop_ok    (stop_ok),
  .ol_ok      (ol_ok),
  .fwd_out    (fwd_out),
  .rev_out    (rev_out)
);

// File: tb/rev_starter_tb_top.sv
`timescale 1ns/1ps
module rev_starter_tb_top;
  localparam int unsigned DLY = 300;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_1ms, fwd_btn, rev_btn, stop_ok, ol_ok;
  logic fwd_out, rev_out;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  rev_starter #(.DELAY_MS(DLY)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1ms (tick_1ms),
    .fwd_btn  (fwd_btn),
    .rev_btn  (rev_btn),
    .stop_ok  (stop_ok),
    .ol_ok    (ol_ok),
    .fwd_out  (fwd_out),
    .rev_out  (rev_out)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // Drive on the falling edge, then sample 1 ns after the rising edge
  task automatic cyc(input logic f, input logic r, input logic s,
                     input logic o, input logic t);
    @(negedge clk);
    fwd_btn = f; rev_btn = r; stop_ok = s; ol_ok = o; tick_1ms = t;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic ef, input logic er);
    n_chk++;
    if (fwd_out !== ef || rev_out !== er) begin
      n_fail++;
      $display("FAIL %s: fwd/rev actual %b%b expected %b%b", req, fwd_out, rev_out, ef, er);
    end
    n_chk++;
    if (fwd_out === 1'b1 && rev_out === 1'b1) begin
      n_fail++;
      $display("FAIL R4: both outputs actual 11 expected not 11");
    end
  endtask

  // Stop once, then let any lockout run out
  task automatic to_idle_clear();
    cyc(0, 0, 0, 1, 0);
    repeat (DLY) cyc(0, 0, 1, 1, 1);
    cyc(0, 0, 1, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tick_1ms = 0; fwd_btn = 0; rev_btn = 0; stop_ok = 1; ol_ok = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 1, 1, 0);
    chk("R1 after reset", 0, 0);
    // R1: no pending lockout, reverse starts at once
    cyc(0, 1, 1, 1, 0);
    chk("R1 R3 start right after reset", 0, 1);
    cyc(0, 0, 1, 1, 0);
    chk("R3 seal-in after release", 0, 1);
    to_idle_clear();

    // Sweep of every input combination from each running state
    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 16; v++) begin
        logic f, r, s, o, ef, er;
        f = v[3]; r = v[2]; s = v[1]; o = v[0];
        to_idle_clear();
        if (st == 1) cyc(1, 0, 1, 1, 0);
        if (st == 2) cyc(0, 1, 1, 1, 0);
        cyc(f, r, s, o, 0);
        ef = 0; er = 0;
        if (s && o) begin
          if (st == 1)      ef = 1;
          else if (st == 2) er = 1;
          else begin
            ef = f && !r;
            er = r && !f;
          end
        end
        if (!s)           chk("R5 stop sweep", ef, er);
        else if (!o)      chk("R6 overload sweep", ef, er);
        else if (st != 0) chk("R7 opposite press ignored sweep", ef, er);
        else if (f && r)  chk("R9 both buttons sweep", ef, er);
        else              chk("R2 R3 start sweep", ef, er);
      end
    end

    // R2 seal-in holds
    to_idle_clear();
    cyc(1, 0, 1, 1, 0);
    repeat (5) cyc(0, 0, 1, 1, 1);
    chk("R2 forward seal-in", 1, 0);
    // R5 stop, then released: stays off
    cyc(0, 0, 0, 1, 0);
    chk("R5 stop drops", 0, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R5 stays off after stop release", 0, 0);
    // R8 lockout boundary: DLY-1 ticks blocked, DLY ticks allowed
    repeat (DLY - 1) cyc(0, 0, 1, 1, 1);
    cyc(0, 1, 1, 1, 0);
    chk("R8 reverse blocked at DLY-1 ticks", 0, 0);
    cyc(0, 0, 1, 1, 1);
    cyc(0, 1, 1, 1, 0);
    chk("R8 reverse allowed at DLY ticks", 0, 1);
    // R8 symmetric, and same-direction restart not blocked
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R6 overload drops reverse", 0, 0);
    cyc(1, 0, 1, 1, 0);
    chk("R8 forward blocked right after reverse drop", 0, 0);
    cyc(0, 1, 1, 1, 0);
    chk("R8 same direction restart", 0, 1);
    // R6 no start while overload low
    to_idle_clear();
    cyc(1, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R6 press during overload ignored", 0, 0);

    finish_run();
  end
endmodule